// File: doc/BRIEF.md
# Pulsed and Continuous Linear-FM Chirp Generator

This block synthesises a complex baseband chirp at one sample per clock. A second-order phase accumulator sweeps the frequency linearly. The frequency word grows by a fixed step each cycle, and the phase grows by the frequency word. The phase is mapped to cosine (I) and sine (Q) through a quarter-wave folded sine table. A burst state machine decides when the transmitter is active. It can make a train of pulses, a steady tone, or a sweep that repeats without end. In the repeating sweep, a one-cycle low gap on the activity flag restarts the oscillator.

Software sets the parameters and then raises `start`. The block latches every parameter on the rising edge and then runs without further help. The sample outputs have no ready input. A sample is valid exactly in the cycles where `tx_active` is high, and the consumer must take it in that cycle, because the block cannot be held back. Outside those cycles, I and Q are zero.

Top module: `chirp_synth`

## Requirements
- R1: During reset and after it, with `start` low, `tx_active` is 0 and `out_i`/`out_q` are 0.
- R2: A 0-to-1 change of `start`, seen at two consecutive clock edges while idle, launches a burst. `tx_active` is first high in the cycle after the edge that saw `start` high. Mode, frequency words, pulse width, repetition interval and pulse count are latched at that edge.
- R3: In pulsed mode (`mode` = 0), `tx_active` is high for the first `pulse_len` cycles of each `pri_len`-cycle interval, for `pulse_num` intervals, and then stays low.
- R4: Whenever `tx_active` is low, `out_i` and `out_q` are exactly 0.
- R5: At the k-th active sample after a restart (k = 0 first), the phase is (k*f0 + step*k*(k-1)/2) mod 2^32. A restart happens at the start of every pulse.
- R6: With a = phase[31:22], `out_q` = round(32767*sin(2*pi*(a+0.5)/1024)) and `out_i` = round(32767*cos(2*pi*(a+0.5)/1024)), as signed 16-bit values.
- R7: In tone mode (`mode` = 1), `tx_active` stays high while `start` is held. The step is ignored, so the phase at sample k is k*f0.
- R8: In repeating-sweep mode (`mode` = 2), `tx_active` is high for `pulse_len` cycles and then low for exactly one cycle, repeating while `start` is held. Each high run restarts the sweep. Neither `pri_len` nor `pulse_num` has any effect.
- R9: After a pulsed burst, `tx_active` stays low while `start` stays high. In tone or sweep mode, dropping `start` makes `tx_active` low in the next cycle.
- R10: Once launched, a burst ignores later changes on all inputs, `start` toggles included, until it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch control; the rising edge starts a burst |
| mode | input | 2 | 0 pulsed, 1 tone, 2 repeating sweep, 3 reserved (acts as pulsed) |
| freq_start | input | PHASE_W | Initial frequency word f0 |
| freq_step | input | PHASE_W | Frequency increment per cycle |
| pulse_len | input | CNT_W | Active cycles per pulse or sweep (at least 1) |
| pri_len | input | CNT_W | Cycles per pulse interval, not less than pulse_len |
| pulse_num | input | CNT_W | Pulses per burst (at least 1) |
| out_i | output | SAMP_W | In-phase sample, signed |
| out_q | output | SAMP_W | Quadrature sample, signed |
| tx_active | output | 1 | High when the sample is valid |

## Verification
`tx_active` and both samples change one clock after the edge that first sees `start` high. The samples are decoded combinationally from the phase register, so they share the cycle of `tx_active` with no extra delay. A stop, caused by releasing `start` in tone or sweep mode, shows one cycle later. The bench drives inputs and samples outputs on the falling edge, and counts sample index t = 0 from the first falling edge after the launching rising edge. From t it computes the expected activity, the phase, and the table value with a rounding tolerance of one LSB.

// File: rtl/chirp_pkg.sv
`timescale 1ns/1ps
package chirp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } burst_state_e;

  typedef enum logic [1:0] {
    MODE_PULSED = 2'd0,
    MODE_TONE   = 2'd1,
    MODE_SWEEP  = 2'd2,
    MODE_RSVD   = 2'd3
  } tx_mode_e;
endpackage

// File: rtl/chirp_sine_lut.sv
`timescale 1ns/1ps
// Quarter-wave folded sine lookup; half-step offset makes folding exact.
module chirp_sine_lut #(
  parameter int ADDR_W = 10,
  parameter int SAMP_W = 16
) (
  input  logic [ADDR_W-1:0]        addr,
  output logic signed [SAMP_W-1:0] value
);
  localparam int    QW   = ADDR_W - 2;
  localparam int    QN   = 1 << QW;
  localparam real   AMP  = real'((1 << (SAMP_W - 1)) - 1);
  localparam real   PI_R = 3.14159265358979323846;

  function automatic logic [SAMP_W-1:0] quarter_entry(input int j);
    real x;
    x = AMP * $sin(2.0 * PI_R * (real'(j) + 0.5) / real'(4 * QN));
    return SAMP_W'($rtoi(x + 0.5));
  endfunction

  logic [SAMP_W-1:0] rom [QN];
  for (genvar j = 0; j < QN; j++) begin : g_rom
    assign rom[j] = quarter_entry(j);
  end

  logic [1:0]    quad;
  logic [QW-1:0] idx, midx;
  logic [SAMP_W-1:0] mag;

  always_comb begin
    quad  = addr[ADDR_W-1:ADDR_W-2];
    idx   = addr[QW-1:0];
    midx  = quad[0] ? ~idx : idx;
    mag   = rom[midx];
    value = quad[1] ? -$signed(mag) : $signed(mag);
  end
endmodule

// File: rtl/chirp_nco.sv
`timescale 1ns/1ps
// Second-order phase accumulator with two table lanes (I = cos, Q = sin).
module chirp_nco #(
  parameter int PHASE_W = 32,
  parameter int LUT_AW  = 10,
  parameter int SAMP_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [PHASE_W-1:0]        freq_init,
  input  logic [PHASE_W-1:0]        freq_step,
  input  logic                      gate,
  output logic signed [SAMP_W-1:0]  out_i,
  output logic signed [SAMP_W-1:0]  out_q,
  output logic [PHASE_W-1:0]        phase,
  output logic [PHASE_W-1:0]        freq
);
  localparam logic [LUT_AW-1:0] QTR = LUT_AW'(1 << (LUT_AW - 2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      freq  <= '0;
    end else if (load) begin
      phase <= '0;
      freq  <= freq_init;
    end else begin
      phase <= phase + freq;
      freq  <= freq + freq_step;
    end
  end

  logic signed [SAMP_W-1:0] lane_val [2];
  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [LUT_AW-1:0] lane_addr;
    assign lane_addr = phase[PHASE_W-1 -: LUT_AW] + ((g == 0) ? QTR : '0);
    chirp_sine_lut #(.ADDR_W(LUT_AW), .SAMP_W(SAMP_W)) u_lut (
      .addr  (lane_addr),
      .value (lane_val[g])
    );
  end

  assign out_i = gate ? lane_val[0] : '0;
  assign out_q = gate ? lane_val[1] : '0;
endmodule

// File: rtl/chirp_burst_fsm.sv
`timescale 1ns/1ps
// Burst timing: launch detect, pulse/interval counting, sweep gap insertion.
module chirp_burst_fsm
  import chirp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode_in,
  input  logic [CNT_W-1:0] plen_in,
  input  logic [CNT_W-1:0] pri_in,
  input  logic [CNT_W-1:0] cnt_in,
  output logic             tx_active,
  output logic             load,
  output logic             capture,
  output burst_state_e     state,
  output tx_mode_e         mode_q
);
  logic             start_q, act_q, act_d;
  burst_state_e     state_q, state_d;
  logic [CNT_W-1:0] plen_q, pri_q, cnt_q;
  logic [CNT_W-1:0] cyc_q, cyc_d, pls_q, pls_d, cyc_inc;

  assign cyc_inc = cyc_q + 1'b1;
  assign capture = (state_q == ST_IDLE) && start && !start_q;

  always_comb begin
    state_d = state_q;
    cyc_d   = cyc_q;
    pls_d   = pls_q;
    act_d   = 1'b0;
    load    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (capture) begin
        state_d = ST_RUN;
        cyc_d   = '0;
        pls_d   = '0;
        act_d   = 1'b1;
        load    = 1'b1;
      end
      ST_RUN: begin
        case (mode_q)
          MODE_TONE: begin
            if (!start) state_d = ST_IDLE;
            else        act_d   = 1'b1;
          end
          MODE_SWEEP: begin
            if (!start) state_d = ST_IDLE;
            else if (cyc_q == plen_q) begin
              cyc_d = '0;
              act_d = 1'b1;
              load  = 1'b1;
            end else begin
              cyc_d = cyc_inc;
              act_d = (cyc_inc != plen_q);
            end
          end
          default: begin
            if (cyc_q == pri_q - 1'b1) begin
              if (pls_q == cnt_q - 1'b1) state_d = ST_DONE;
              else begin
                cyc_d = '0;
                pls_d = pls_q + 1'b1;
                act_d = 1'b1;
                load  = 1'b1;
              end
            end else begin
              cyc_d = cyc_inc;
              act_d = (cyc_inc < plen_q);
            end
          end
        endcase
      end
      ST_DONE: if (!start) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      state_q <= ST_IDLE;
      act_q   <= 1'b0;
      cyc_q   <= '0;
      pls_q   <= '0;
      mode_q  <= MODE_PULSED;
      plen_q  <= '0;
      pri_q   <= '0;
      cnt_q   <= '0;
    end else begin
      start_q <= start;
      state_q <= state_d;
      act_q   <= act_d;
      cyc_q   <= cyc_d;
      pls_q   <= pls_d;
      if (capture) begin
        mode_q <= tx_mode_e'(mode_in);
        plen_q <= plen_in;
        pri_q  <= pri_in;
        cnt_q  <= cnt_in;
      end
    end
  end

  assign tx_active = act_q;
  assign state     = state_q;
endmodule

// File: rtl/chirp_synth.sv
`timescale 1ns/1ps
module chirp_synth
  import chirp_pkg::*;
#(
  parameter int PHASE_W = 32,
  parameter int LUT_AW  = 10,
  parameter int SAMP_W  = 16,
  parameter int CNT_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [1:0]               mode,
  input  logic [PHASE_W-1:0]       freq_start,
  input  logic [PHASE_W-1:0]       freq_step,
  input  logic [CNT_W-1:0]         pulse_len,
  input  logic [CNT_W-1:0]         pri_len,
  input  logic [CNT_W-1:0]         pulse_num,
  output logic signed [SAMP_W-1:0] out_i,
  output logic signed [SAMP_W-1:0] out_q,
  output logic                     tx_active
);
  burst_state_e       fsm_state;
  tx_mode_e           fsm_mode;
  logic               capture, load;
  logic [PHASE_W-1:0] nco_phase, nco_freq;
  logic [PHASE_W-1:0] f0_q, step_q, f0_use;

  chirp_burst_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode_in   (mode),
    .plen_in   (pulse_len),
    .pri_in    (pri_len),
    .cnt_in    (pulse_num),
    .tx_active (tx_active),
    .load      (load),
    .capture   (capture),
    .state     (fsm_state),
    .mode_q    (fsm_mode)
  );

  // Frequency words are latched at launch; tone mode latches a zero step.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f0_q   <= '0;
      step_q <= '0;
    end else if (capture) begin
      f0_q   <= freq_start;
      step_q <= (tx_mode_e'(mode) == MODE_TONE) ? '0 : freq_step;
    end
  end

  assign f0_use = capture ? freq_start : f0_q;

  chirp_nco #(.PHASE_W(PHASE_W), .LUT_AW(LUT_AW), .SAMP_W(SAMP_W)) u_nco (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .freq_init (f0_use),
    .freq_step (step_q),
    .gate      (tx_active),
    .out_i     (out_i),
    .out_q     (out_q),
    .phase     (nco_phase),
    .freq      (nco_freq)
  );
endmodule

// File: rtl/chirp_synth_chk.sv
`timescale 1ns/1ps
module chirp_synth_chk
  import chirp_pkg::*;
#(
  parameter int PHASE_W = 32,
  parameter int SAMP_W  = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start,
  input logic                     tx_active,
  input logic signed [SAMP_W-1:0] out_i,
  input logic signed [SAMP_W-1:0] out_q,
  input burst_state_e             state,
  input tx_mode_e                 mode,
  input logic [PHASE_W-1:0]       phase,
  input logic [PHASE_W-1:0]       freq
);
  assert_zero_when_inactive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |-> (out_i == '0 && out_q == '0));

  assert_restart_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_active) |-> (phase == '0));

  assert_done_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE) |-> !tx_active);

  assert_tone_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && mode == MODE_TONE) |-> tx_active);

  assert_tone_freq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && mode == MODE_TONE && $past(state) == ST_RUN) |-> $stable(freq));

  assert_sweep_gap_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tx_active) && state == ST_RUN && mode == MODE_SWEEP && start) |=> tx_active);
endmodule

bind chirp_synth chirp_synth_chk #(.PHASE_W(PHASE_W), .SAMP_W(SAMP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .tx_active (tx_active),
  .out_i     (out_i),
  .out_q     (out_q),
  .state     (fsm_state),
  .mode      (fsm_mode),
  .phase     (nco_phase),
  .freq      (nco_freq)
);

// File: tb/chirp_synth_tb_top.sv
`timescale 1ns/1ps
module chirp_synth_tb_top;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start = 1'b0;
  logic [1:0]         mode = 2'd0;
  logic [31:0]        freq_start = '0, freq_step = '0;
  logic [15:0]        pulse_len = 16'd1, pri_len = 16'd1, pulse_num = 16'd1;
  logic signed [15:0] out_i, out_q;
  logic               tx_active;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  chirp_synth dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .freq_start(freq_start), .freq_step(freq_step),
    .pulse_len(pulse_len), .pri_len(pri_len), .pulse_num(pulse_num),
    .out_i(out_i), .out_q(out_q), .tx_active(tx_active)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_phase(input int unsigned k,
                                            input logic [31:0] f0,
                                            input logic [31:0] st);
    longint unsigned kk = k;
    longint unsigned tri_n = (kk == 0) ? 0 : kk * (kk - 1) / 2;
    return 32'(kk * f0 + tri_n * st);
  endfunction

  function automatic int exp_wave(input int a);
    real m = 32767.0 * $sin(2.0 * 3.14159265358979 * (real'(a) + 0.5) / 1024.0);
    if (m >= 0.0) return $rtoi(m + 0.5);
    return -$rtoi(0.5 - m);
  endfunction

  function automatic int absdiff(input int x, input int y);
    return (x > y) ? x - y : y - x;
  endfunction

  task automatic check_sample(input string req_t, input bit act_exp, input logic [31:0] ph);
    int a, ei, eq;
    chk(tx_active == act_exp, req_t, "tx_active", tx_active, act_exp);
    if (act_exp) begin
      a  = int'(ph[31:22]);
      eq = exp_wave(a);
      ei = exp_wave((a + 256) % 1024);
      chk(absdiff(int'(out_i), ei) <= 1, "R5/R6", "out_i", out_i, ei);
      chk(absdiff(int'(out_q), eq) <= 1, "R5/R6", "out_q", out_q, eq);
    end else begin
      chk(out_i == 0 && out_q == 0, "R4", "idle I/Q", {out_i, out_q}, 0);
    end
  endtask

  task automatic scramble_inputs(input bit keep_start);
    mode       = 2'($urandom);
    freq_start = $urandom;
    freq_step  = $urandom;
    pulse_len  = 16'($urandom % 20);
    pri_len    = 16'($urandom % 20);
    pulse_num  = 16'($urandom % 5);
    if (!keep_start) start = 1'($urandom);
    else             start = 1'b1;
  endtask

  task automatic run_pulsed(input logic [31:0] f0, input logic [31:0] st,
                            input int plen, input int pri, input int cnt, input bit scram);
    int total = cnt * pri;
    @(negedge clk);
    mode = 2'd0; freq_start = f0; freq_step = st;
    pulse_len = 16'(plen); pri_len = 16'(pri); pulse_num = 16'(cnt);
    start = 1'b1;
    for (int t = 0; t < total + 4; t++) begin
      @(negedge clk);
      if (t < total)
        check_sample(t == 0 ? "R2" : (scram ? "R10" : "R3"), (t % pri) < plen,
                     exp_phase(t % pri, f0, st));
      else
        check_sample("R9", 1'b0, '0);
      if (scram) scramble_inputs(t >= total - 3);
    end
    start = 1'b1;
    @(negedge clk);
    check_sample("R9", 1'b0, '0);
    start = 1'b0;
    @(negedge clk);
    check_sample("R9", 1'b0, '0);
  endtask

  task automatic run_cont(input bit sweep, input logic [31:0] f0, input logic [31:0] st,
                          input int plen, input int ncyc, input bit scram);
    @(negedge clk);
    mode = sweep ? 2'd2 : 2'd1; freq_start = f0; freq_step = st;
    pulse_len = 16'(plen); pri_len = 16'd2; pulse_num = 16'd1;
    start = 1'b1;
    for (int t = 0; t < ncyc; t++) begin
      @(negedge clk);
      if (sweep)
        check_sample("R8", (t % (plen + 1)) < plen, exp_phase(t % (plen + 1), f0, st));
      else
        check_sample("R7", 1'b1, exp_phase(t, f0, 32'd0));
      if (scram) scramble_inputs(1'b1);
    end
    start = 1'b0;
    @(negedge clk);
    check_sample("R9", 1'b0, '0);
    @(negedge clk);
    check_sample("R9", 1'b0, '0);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) begin
      @(negedge clk);
      check_sample("R1", 1'b0, '0);
    end
    rst_n = 1'b1;
    repeat (2) begin
      @(negedge clk);
      check_sample("R1", 1'b0, '0);
    end

    run_pulsed(32'h0100_0000, 32'h0020_0000, 3, 5, 2, 1'b0);   // R3 basic train
    run_pulsed(32'h0400_0000, 32'h0100_0000, 4, 4, 3, 1'b0);   // R5 back-to-back restart
    run_pulsed(32'h1234_5678, 32'h0000_1000, 1, 1, 1, 1'b0);   // R3 minimal burst
    run_pulsed(32'h0080_0000, 32'h0003_0000, 5, 9, 3, 1'b1);   // R10 scrambled inputs
    run_cont(1'b0, 32'h0312_0000, 32'h0FFF_0000, 3, 24, 1'b0); // R7 step ignored
    run_cont(1'b1, 32'h0200_0000, 32'h0040_0000, 4, 30, 1'b0); // R8 gap every 5
    run_cont(1'b1, 32'h0700_0000, 32'h0001_0000, 1, 10, 1'b1); // R8 shortest sweep

    for (int r = 0; r < 12; r++) begin
      int m    = $urandom % 3;
      int plen = 1 + $urandom % 10;
      int pri  = plen + $urandom % 6;
      int cnt  = 1 + $urandom % 4;
      logic [31:0] f0 = $urandom;
      logic [31:0] st = $urandom;
      bit sc = 1'($urandom);
      if (m == 0)      run_pulsed(f0, st, plen, pri, cnt, sc);
      else             run_cont(m == 2, f0, st, plen, 20 + $urandom % 20, sc);
    end

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule